// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash bus. A client hands it one request at a time over a valid/ready handshake. Each request carries an operation code, a byte address, a data byte and a choice of completion check. The block drives the unlock and command write cycles the flash expects. Each write cycle is a chip-enable-low window with a write-enable pulse, and the widths of its phases are set by parameters counted in clock cycles. After the last write pulse the block reads the target location again and again until the flash's own status bits show that the internal operation has finished.

Completion is judged in one of two ways. In toggle mode, bit 6 of each read is compared with bit 6 of the read before it. In data mode, bit 7 is compared with the value it must settle to. The first read that looks complete is only a candidate. Two further reads must each pass the same test before the block reports done, so a read that lands at the moment of completion cannot end the wait early. A timer, started when polling begins, ends the request with an error pulse if completion is never confirmed.

The flash data bus is split into an output byte, an input byte and a drive enable, so the tri-state buffer sits outside the block.

Top module: `flash_prog_seq`

## Requirements
- R1: For program requests (req_op = 0), exactly four write cycles are emitted, in this order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then req_data at req_addr. On the command cycles the address bits above bit 14 are zero.
- R2: For erase requests, exactly six write cycles are emitted: AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then a final cycle. The final cycle is 30h at req_addr for req_op = 1 (sector), 50h at req_addr for req_op = 2 (block), and 10h at 5555h for req_op = 3 (chip).
- R3: In every write cycle, CE# is low and OE# is high when WE# falls. WE# stays low for exactly WE_LOW_CYC clock cycles, and address and output data stay stable while WE# is low. OE# and WE# are never low together.
- R4: Polling reads (CE# and OE# low, WE# high) start only after the final write pulse of the request has risen.
- R5: With req_poll_dq7 = 0, the first poll read is a baseline only. A later read becomes a completion candidate when its bit 6 equals bit 6 of the read before it.
- R6: With req_poll_dq7 = 1, a read is a candidate when bit 7 equals bit 7 of the programmed byte (program), or when bit 7 reads 1 (any erase).
- R7: After a candidate, two more reads must each pass the same test; if either fails, polling resumes. done is a one-cycle pulse, raised only after both re-reads pass.
- R8: If completion is not confirmed within TIMEOUT_CYC cycles of the start of polling, err pulses for one cycle at the end of the read in progress, and done does not pulse. done and err never pulse together.
- R9: req_ready drops in the cycle after a request is accepted and returns in the cycle where done or err pulses. A request held valid while the block is busy starts no bus activity.
- R10: After reset, req_ready is 1, CE#, OE# and WE# are high, the drive enable is 0, and done and err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | ADDR_W | Target byte, sector or block address |
| req_data | input | 8 | Byte to program |
| req_poll_dq7 | input | 1 | 1: check bit 7 against its settled value; 0: compare bit 6 between reads |
| done | output | 1 | One-cycle pulse on confirmed completion |
| err | output | 1 | One-cycle pulse on timeout |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dout | output | 8 | Byte driven onto the flash data bus |
| fl_drive | output | 1 | Enables the external data bus driver |
| fl_din | input | 8 | Byte read from the flash data bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
Each of the four operation codes is run at least once, in both completion modes. This separates the four-cycle program sequence from the six-cycle erase sequences, and the sector and block final cycles from the chip one. In data mode the number of reads up to done is fixed by how long the flash model stays busy, so a missing or extra confirmation read shows as a count error. In toggle mode the model's bit 6 alternates, so a block that does not compare consecutive reads fails. Two glitch patterns are also run: one read in data mode shows the settled bit 7 early, and in toggle mode bit 6 repeats once, both while the model is still busy. Only the two confirmation re-reads keep done from pulsing while the model is busy in these runs. A model that never finishes exercises the timeout, and a second request held valid for a whole operation shows that nothing new is started.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_BLOCK, OP_CHIP} fseq_op_e;
  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_ACT, B_REC} fseq_bus_e;
  typedef enum logic [2:0] {S_IDLE, S_WR, S_WR_W, S_RD, S_RD_W} fseq_st_e;
  typedef enum logic [1:0] {PH_BASE, PH_POLL, PH_CONF1, PH_CONF2} fseq_ph_e;

  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;

  // Index of the final write cycle for an operation
  function automatic logic [2:0] last_step(fseq_op_e op);
    return (op == OP_PROG) ? 3'd3 : 3'd5;
  endfunction

  // Data byte driven in write cycle s
  function automatic logic [7:0] step_data(fseq_op_e op, logic [2:0] s, logic [7:0] wd);
    logic [7:0] v;
    case (s)
      3'd0: v = 8'hAA;
      3'd1: v = 8'h55;
      3'd2: v = (op == OP_PROG) ? 8'hA0 : 8'h80;
      3'd3: v = (op == OP_PROG) ? wd : 8'hAA;
      3'd4: v = 8'h55;
      default: begin
        case (op)
          OP_SECT:  v = 8'h30;
          OP_BLOCK: v = 8'h50;
          default:  v = 8'h10;
        endcase
      end
    endcase
    return v;
  endfunction

  // Write cycle s carries the request address instead of a key address
  function automatic logic step_uses_target(fseq_op_e op, logic [2:0] s);
    return ((op == OP_PROG) && (s == 3'd3)) ||
           (((op == OP_SECT) || (op == OP_BLOCK)) && (s == 3'd5));
  endfunction

  function automatic logic [14:0] step_key_addr(logic [2:0] s);
    return ((s == 3'd1) || (s == 3'd4)) ? KEY_ADDR_B : KEY_ADDR_A;
  endfunction

endpackage

// File: rtl/fseq_bus_cycle.sv
module fseq_bus_cycle
  import fseq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SETUP_CYC   = 1,
  parameter int WE_LOW_CYC  = 2,
  parameter int WE_HIGH_CYC = 2,
  parameter int RD_WAIT_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        data_in,
  output logic              idle,
  output logic              cyc_done,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dout,
  output logic              fl_drive,
  input  logic [7:0]        fl_din,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  localparam int M1 = (SETUP_CYC > WE_LOW_CYC) ? SETUP_CYC : WE_LOW_CYC;
  localparam int M2 = (WE_HIGH_CYC > RD_WAIT_CYC) ? WE_HIGH_CYC : RD_WAIT_CYC;
  localparam int MX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MX + 1);

  fseq_bus_e st, nst;
  logic [CW-1:0] cnt, ncnt;
  logic wr_q, nwr;

  assign idle     = (st == B_IDLE);
  assign cyc_done = (st == B_REC) && (cnt == '0);
  assign nwr      = ((st == B_IDLE) && start) ? is_wr : wr_q;

  always_comb begin
    nst  = st;
    ncnt = cnt;
    case (st)
      B_IDLE: if (start) begin
        nst  = B_SETUP;
        ncnt = CW'(SETUP_CYC - 1);
      end
      B_SETUP: if (cnt == '0) begin
        nst  = B_ACT;
        ncnt = wr_q ? CW'(WE_LOW_CYC - 1) : CW'(RD_WAIT_CYC - 1);
      end else ncnt = cnt - 1'b1;
      B_ACT: if (cnt == '0) begin
        nst  = B_REC;
        ncnt = CW'(WE_HIGH_CYC - 1);
      end else ncnt = cnt - 1'b1;
      default: if (cnt == '0) nst = B_IDLE;
               else ncnt = cnt - 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      rdata    <= '0;
      fl_addr  <= '0;
      fl_dout  <= '0;
      fl_drive <= 1'b0;
      fl_ce_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
      fl_we_n  <= 1'b1;
    end else begin
      st       <= nst;
      cnt      <= ncnt;
      wr_q     <= nwr;
      fl_ce_n  <= (nst == B_IDLE);
      fl_oe_n  <= !((nst == B_ACT) && !nwr);
      fl_we_n  <= !((nst == B_ACT) && nwr);
      fl_drive <= (nst != B_IDLE) && nwr;
      if ((st == B_IDLE) && start) begin
        fl_addr <= addr_in;
        fl_dout <= data_in;
      end
      if ((st == B_ACT) && (cnt == '0) && !wr_q) rdata <= fl_din;
    end
  end

  p_oe_we_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(!fl_oe_n && !fl_we_n));
  p_we_fall_oe_high_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we_n) |-> (fl_oe_n && !fl_ce_n));
  p_bus_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

endmodule

// File: rtl/fseq_poll_judge.sv
module fseq_poll_judge (
  input  logic use_dq7,
  input  logic is_prog,
  input  logic wbit7,
  input  logic ref_dq6,
  input  logic rd_dq7,
  input  logic rd_dq6,
  output logic pass
);

  logic dq7_ok, dq6_ok;

  // Data mode: bit 7 settles to the written bit (program) or to 1 (erase)
  assign dq7_ok = is_prog ? (rd_dq7 == wbit7) : rd_dq7;
  // Toggle mode: bit 6 no longer alternating between consecutive reads
  assign dq6_ok = (rd_dq6 == ref_dq6);
  assign pass   = use_dq7 ? dq7_ok : dq6_ok;

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int LIMIT = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  assign expired = (cnt == TW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(LIMIT));
  p_expire_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (expired && !clear) |=> expired);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SETUP_CYC   = 1,
  parameter int WE_LOW_CYC  = 2,
  parameter int WE_HIGH_CYC = 2,
  parameter int RD_WAIT_CYC = 3,
  parameter int TIMEOUT_CYC = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              req_poll_dq7,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dout,
  output logic              fl_drive,
  input  logic [7:0]        fl_din,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  fseq_st_e          st;
  fseq_ph_e          ph, ph_nxt;
  fseq_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              dq7_q;
  logic [2:0]        step_q;
  logic [7:0]        prev_q;

  logic              bus_idle, bus_done, bus_start, bus_wr;
  logic [7:0]        bus_rdata, bus_wdata;
  logic [ADDR_W-1:0] bus_addr;
  logic              pass, expired, accept, finish;

  assign accept    = (st == S_IDLE) && req_valid;
  assign bus_start = ((st == S_WR) || (st == S_RD)) && bus_idle;
  assign bus_wr    = (st == S_WR);
  assign bus_addr  = ((st == S_RD) || step_uses_target(op_q, step_q)) ? addr_q
                   : ADDR_W'(step_key_addr(step_q));
  assign bus_wdata = step_data(op_q, step_q, data_q);

  fseq_bus_cycle #(
    .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC), .WE_LOW_CYC(WE_LOW_CYC),
    .WE_HIGH_CYC(WE_HIGH_CYC), .RD_WAIT_CYC(RD_WAIT_CYC)
  ) u_bus (
    .clk(clk), .rst(rst), .start(bus_start), .is_wr(bus_wr),
    .addr_in(bus_addr), .data_in(bus_wdata), .idle(bus_idle),
    .cyc_done(bus_done), .rdata(bus_rdata), .fl_addr(fl_addr),
    .fl_dout(fl_dout), .fl_drive(fl_drive), .fl_din(fl_din),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  fseq_poll_judge u_judge (
    .use_dq7(dq7_q), .is_prog(op_q == OP_PROG), .wbit7(data_q[7]),
    .ref_dq6(prev_q[6]), .rd_dq7(bus_rdata[7]), .rd_dq6(bus_rdata[6]),
    .pass(pass)
  );

  fseq_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .clear(accept),
    .run((st == S_RD) || (st == S_RD_W)), .expired(expired)
  );

  always_comb begin
    case (ph)
      PH_BASE:  ph_nxt = PH_POLL;
      PH_POLL:  ph_nxt = pass ? PH_CONF1 : PH_POLL;
      PH_CONF1: ph_nxt = pass ? PH_CONF2 : PH_POLL;
      default:  ph_nxt = PH_POLL;
    endcase
  end

  assign finish = (ph == PH_CONF2) && pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ph        <= PH_BASE;
      op_q      <= OP_PROG;
      addr_q    <= '0;
      data_q    <= '0;
      dq7_q     <= 1'b0;
      step_q    <= '0;
      prev_q    <= '0;
      req_ready <= 1'b1;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q      <= fseq_op_e'(req_op);
          addr_q    <= req_addr;
          data_q    <= req_data;
          dq7_q     <= req_poll_dq7;
          step_q    <= '0;
          ph        <= req_poll_dq7 ? PH_POLL : PH_BASE;
          req_ready <= 1'b0;
          st        <= S_WR;
        end
        S_WR: if (bus_start) st <= S_WR_W;
        S_WR_W: if (bus_done) begin
          if (step_q == last_step(op_q)) st <= S_RD;
          else begin
            step_q <= step_q + 1'b1;
            st     <= S_WR;
          end
        end
        S_RD: if (bus_start) st <= S_RD_W;
        S_RD_W: if (bus_done) begin
          prev_q <= bus_rdata;
          if (finish) begin
            done      <= 1'b1;
            req_ready <= 1'b1;
            st        <= S_IDLE;
          end else if (expired) begin
            err       <= 1'b1;
            req_ready <= 1'b1;
            st        <= S_IDLE;
          end else begin
            ph <= ph_nxt;
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_flag_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_ready_back_r9: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> req_ready);
  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |-> !req_ready);
  p_read_after_writes_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_start && !bus_wr) |-> (step_q == last_step(op_q)));

endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 20;
  localparam int WE_LOW     = 2;
  localparam int TMO        = 400;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = 8'h00;
  logic          req_poll_dq7 = 1'b0;
  logic          done, err;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dout;
  logic          fl_drive;
  logic [7:0]    fl_din;
  logic          fl_ce_n, fl_oe_n, fl_we_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_seq #(
    .ADDR_W(AW), .SETUP_CYC(1), .WE_LOW_CYC(WE_LOW), .WE_HIGH_CYC(2),
    .RD_WAIT_CYC(3), .TIMEOUT_CYC(TMO)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .req_poll_dq7(req_poll_dq7), .done(done), .err(err),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_drive(fl_drive),
    .fl_din(fl_din), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_we_cyc = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected write cycles
  logic [AW-1:0] q_addr[$];
  logic [7:0]    q_data[$];

  // Behavioural flash: configured by the driver, armed after the final write
  int   cfg_busy = 0, cfg_glitch = -1;
  bit   cfg_prog = 0, cfg_dq7 = 0;
  logic [7:0] cfg_data = 8'h00;
  int   m_left = 0, m_glitch = -1, m_idx = 0, m_reads = 0;
  bit   m_prog = 0, m_dq7 = 0, m_tog = 0;
  logic [7:0] m_data = 8'h00;

  always_comb begin
    if (m_left != 0) begin
      if (m_idx == m_glitch)
        fl_din = m_dq7 ? {(m_prog ? m_data[7] : 1'b1), m_tog, 6'h2A}
                       : {(m_prog ? ~m_data[7] : 1'b0), ~m_tog, 6'h2A};
      else
        fl_din = {(m_prog ? ~m_data[7] : 1'b0), m_tog, 6'h15};
    end else begin
      fl_din = m_prog ? m_data : 8'hFF;
    end
  end

  logic          we_prev = 1'b1, oe_prev = 1'b1;
  logic [AW-1:0] w_addr;
  logic [7:0]    w_data;
  int            low_n = 0;

  // Per-clock bus monitor and write-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(!(!fl_oe_n && !fl_we_n), "R3 oe and we low together", {fl_oe_n, fl_we_n}, 2'b11);
      if (we_prev && !fl_we_n) begin
        w_addr = fl_addr;
        w_data = fl_dout;
        low_n  = 1;
        check(fl_oe_n && !fl_ce_n && fl_drive, "R3 levels at we fall",
              {fl_ce_n, fl_oe_n, fl_drive}, 3'b011);
      end else if (!we_prev && !fl_we_n) begin
        low_n++;
        check(fl_addr == w_addr && fl_dout == w_data, "R3 bus hold",
              {fl_addr, fl_dout}, {w_addr, w_data});
      end else if (!we_prev && fl_we_n) begin
        check(low_n == WE_LOW, "R3 we low width", low_n, WE_LOW);
        last_we_cyc = cyc;
        if (q_addr.size() == 0) begin
          check(1'b0, "R9 unexpected write", {w_addr, w_data}, 0);
        end else begin
          check(w_addr == q_addr[0] && w_data == q_data[0],
                cfg_prog ? "R1 write cycle" : "R2 write cycle",
                {w_addr, w_data}, {q_addr[0], q_data[0]});
          void'(q_addr.pop_front());
          void'(q_data.pop_front());
          if (q_addr.size() == 0) begin
            m_left = cfg_busy; m_glitch = cfg_glitch; m_idx = 0; m_reads = 0;
            m_prog = cfg_prog; m_dq7 = cfg_dq7; m_data = cfg_data; m_tog = 1'b0;
          end
        end
      end
      if (oe_prev && !fl_oe_n)
        check(fl_we_n && q_addr.size() == 0, "R4 read before final write",
              q_addr.size(), 0);
      if (!oe_prev && fl_oe_n) begin
        m_reads++;
        if (m_left != 0) begin
          if (m_idx != m_glitch) m_tog = ~m_tog;
          m_idx++;
          if (m_left > 0) m_left--;
        end
      end
    end
    we_prev = fl_we_n;
    oe_prev = fl_oe_n;
  end

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                        input bit dq7, input int busy, input int glitch,
                        input bit expect_err, input bit hammer, input string tag);
    int n;
    bit got_done, got_err;
    int end_cyc;
    q_addr.push_back(AW'(20'h05555)); q_data.push_back(8'hAA);
    q_addr.push_back(AW'(20'h02AAA)); q_data.push_back(8'h55);
    if (op == 2'd0) begin
      q_addr.push_back(AW'(20'h05555)); q_data.push_back(8'hA0);
      q_addr.push_back(a);              q_data.push_back(d);
    end else begin
      q_addr.push_back(AW'(20'h05555)); q_data.push_back(8'h80);
      q_addr.push_back(AW'(20'h05555)); q_data.push_back(8'hAA);
      q_addr.push_back(AW'(20'h02AAA)); q_data.push_back(8'h55);
      case (op)
        2'd1:    begin q_addr.push_back(a); q_data.push_back(8'h30); end
        2'd2:    begin q_addr.push_back(a); q_data.push_back(8'h50); end
        default: begin q_addr.push_back(AW'(20'h05555)); q_data.push_back(8'h10); end
      endcase
    end
    cfg_busy = busy; cfg_glitch = glitch; cfg_prog = (op == 2'd0);
    cfg_dq7 = dq7; cfg_data = d;

    @(negedge clk);
    check(req_ready == 1'b1, {tag, " R9 ready before request"}, req_ready, 1);
    req_op = op; req_addr = a; req_data = d; req_poll_dq7 = dq7; req_valid = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b0, {tag, " R9 ready after accept"}, req_ready, 0);
    req_valid = hammer;
    if (hammer) begin
      req_op = 2'd3; req_addr = ~a; req_data = ~d; req_poll_dq7 = ~dq7;
    end
    n = 0;
    while (!(done || err) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    got_done = done; got_err = err; end_cyc = cyc;
    if (!(got_done || got_err)) check(1'b0, {tag, " R7 no completion seen"}, n, 0);
    check(req_ready == 1'b1, {tag, " R9 ready with end pulse"}, req_ready, 1);
    check(q_addr.size() == 0, {tag, " R1 R2 writes outstanding"}, q_addr.size(), 0);
    if (expect_err) begin
      check(got_err && !got_done, {tag, " R8 error pulse"}, {got_done, got_err}, 2'b01);
      check(end_cyc - last_we_cyc >= TMO && end_cyc - last_we_cyc <= TMO + 16,
            {tag, " R8 timeout window"}, end_cyc - last_we_cyc, TMO);
    end else begin
      check(got_done && !got_err, {tag, " R7 done pulse"}, {got_done, got_err}, 2'b10);
      check(m_left == 0, {tag, " R7 done while flash busy"}, m_left, 0);
      if (dq7)
        check(m_reads == busy + 3, {tag, " R6 poll read count"}, m_reads, busy + 3);
      else
        check(m_reads == busy + 3 || m_reads == busy + 4, {tag, " R5 poll read count"},
              m_reads, busy + 3);
    end
    @(negedge clk);
    check(!done && !err, {tag, " R7 single-cycle pulse"}, {done, err}, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (hammer || i == 0)
        check(fl_ce_n == 1'b1, {tag, " R9 bus quiet after end"}, fl_ce_n, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
    check({fl_ce_n, fl_oe_n, fl_we_n} == 3'b111, "R10 reset strobes",
          {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
    check(!fl_drive && !done && !err, "R10 reset flags", {fl_drive, done, err}, 0);

    run_op(2'd0, 20'hABCDE, 8'h3C, 1'b1, 4, -1, 1'b0, 1'b0, "prog data");
    run_op(2'd0, 20'h01234, 8'hC5, 1'b0, 5, -1, 1'b0, 1'b0, "prog toggle");
    run_op(2'd1, 20'h7F123, 8'h00, 1'b1, 3, -1, 1'b0, 1'b0, "sector data");
    run_op(2'd2, 20'hE0000, 8'h00, 1'b0, 4, -1, 1'b0, 1'b0, "block toggle");
    run_op(2'd3, 20'h00042, 8'h00, 1'b1, 2, -1, 1'b0, 1'b0, "chip data");
    run_op(2'd3, 20'h00042, 8'h00, 1'b0, 3, -1, 1'b0, 1'b0, "chip toggle");
    run_op(2'd0, 20'h5A5A5, 8'hA7, 1'b1, 6, 1, 1'b0, 1'b0, "R7 glitch data");
    run_op(2'd0, 20'h33333, 8'h18, 1'b0, 6, 2, 1'b0, 1'b0, "R7 glitch toggle");
    run_op(2'd1, 20'h44000, 8'h00, 1'b1, 5, 1, 1'b0, 1'b0, "R7 glitch erase");
    run_op(2'd0, 20'h12345, 8'h66, 1'b1, 3, -1, 1'b0, 1'b1, "R9 held request");
    run_op(2'd1, 20'h20000, 8'h00, 1'b1, -1, -1, 1'b1, 1'b0, "R8 timeout");
    run_op(2'd0, 20'h00F00, 8'h81, 1'b1, 2, -1, 1'b0, 1'b0, "after timeout");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule